// File: doc/BRIEF.md
# Hardware Cursor Register Bank

This block holds the programmable state of a display hardware cursor. It turns that state into the signals a cursor renderer uses. Software writes registers through a simple bus that has a write strobe, a register address and 32 bits of write data. Every write lands in a pending copy of the register. The renderer only ever sees an active copy. The active copy is loaded from the pending copy at a commit point, so a half-programmed cursor never reaches the screen.

A commit point can arise in two ways. While the update-lock bit is set, nothing is committed and frame-start pulses are ignored. Clearing the lock commits every pending field at once. While the lock is clear, each frame-start pulse commits the pending state.

The surface base address is 40 bits wide and split into a high byte and a low word. It commits only when its low word was written after its high byte. Software therefore writes the high byte first and the low word last. Size is stored as dimension minus one and decoded on the outputs. Both views can be read back, pending and active, at any time.

Top module: `cursor_regbank`

## Requirements
- R1: After synchronous reset the lock bit is 0 and every active output is 0, except width and height, which read 1. Both readback views return 0 at every address.
- R2: A write changes the pending readback (rd_view=0) on the next cycle. It leaves every active output and the active readback (rd_view=1) unchanged until a commit.
- R3: While the lock bit (address 0, bit 0) is 1, frame_start pulses commit nothing.
- R4: Writing 0 to the lock bit while it is 1 commits all pending fields together at that clock edge, so the outputs show them on the next cycle.
- R5: With the lock bit 0, a frame_start pulse commits all pending fields at that edge.
- R6: The size register (address 6) holds width-1 in bits 7:0 and height-1 in bits 15:8. cur_width and cur_height output the stored value plus one, in the range 1 to 256.
- R7: A low-address write (address 8) arms the address for commit and a high-address write (address 7, bits 7:0) disarms it. A commit updates cur_base_addr only when armed; otherwise the previous address stays active.
- R8: cur_base_addr is {high byte, low word} with bits 11:0 forced to 0. The pending readback of address 8 returns all 32 bits as written, and the active readback returns bits 11:0 as 0.
- R9: The control register (address 1) holds enable in bit 0, mode in bits 2:1 (0 mono, 1 colour with 1-bit AND mask, 2 pre-multiplied alpha, 3 straight alpha), magnify in bit 3 and inverse-transparent clamp in bit 4.
- R10: Writing 0 to the lock bit while it is already 0 commits nothing.
- R11: The other field layouts are fixed:
  - Position (address 2): X in bits 12:0, Y in bits 28:16.
  - Hotspot (address 3): X in bits 7:0, Y in bits 15:8.
  - Colours (addresses 4 and 5): blue in bits 7:0, green in bits 15:8, red in bits 23:16.
  - Unused bits, and addresses above 8, read as 0.
  - Writes to addresses above 8 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| frame_start | input | 1 | Frame-start pulse; commits when unlocked |
| rd_addr | input | 4 | Register read address |
| rd_view | input | 1 | 0 reads pending copy, 1 reads active copy |
| rd_data | output | 32 | Readback data (combinational) |
| cur_enable | output | 1 | Cursor visible |
| cur_mode | output | 2 | Cursor colour mode |
| cur_magnify | output | 1 | 2x magnification |
| cur_clamp | output | 1 | Inverse-transparent clamp |
| cur_x | output | 13 | Cursor X position |
| cur_y | output | 13 | Cursor Y position |
| cur_hot_x | output | 8 | Hotspot X |
| cur_hot_y | output | 8 | Hotspot Y |
| cur_color0 | output | 24 | First colour {red, green, blue} |
| cur_color1 | output | 24 | Second colour {red, green, blue} |
| cur_width | output | 9 | Decoded width in pixels |
| cur_height | output | 9 | Decoded height in pixels |
| cur_base_addr | output | 40 | Active 4 KB-aligned surface byte address |

## Verification
A stuck or mis-cleared lock shows up as one of two faults on the cycle after an unlock write or a frame_start pulse. Either outputs that never move, or outputs that change while software still holds the lock. A wrong arm flag shows on cur_base_addr the cycle after the commit: either a stale address where a new one was expected, or a half-written address. Field-placement faults show at once, one cycle after the write, in the pending readback. They reach the cursor outputs one cycle after the next commit.

// File: rtl/cursor_regs_pkg.sv
package cursor_regs_pkg;

    parameter int DATA_W     = 32;
    parameter int ADDR_W     = 4;
    parameter int POS_W      = 13;
    parameter int HOT_W      = 8;
    parameter int SIZE_W     = 8;
    parameter int CHAN_W     = 8;
    parameter int AHI_W      = 8;
    parameter int ALO_W      = 32;
    parameter int ALIGN_BITS = 12;

    localparam int BASE_W     = AHI_W + ALO_W;
    localparam int DIM_W      = SIZE_W + 1;
    localparam int RGB_W      = 3 * CHAN_W;
    localparam int POS_Y_LSB  = 16;
    localparam int HOT_Y_LSB  = 8;
    localparam int SIZE_H_LSB = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_LOCK = 4'd0,
        REG_CTRL = 4'd1,
        REG_POS  = 4'd2,
        REG_HOT  = 4'd3,
        REG_COLA = 4'd4,
        REG_COLB = 4'd5,
        REG_SIZE = 4'd6,
        REG_AHI  = 4'd7,
        REG_ALO  = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        MODE_MONO     = 2'd0,
        MODE_AND_MASK = 2'd1,
        MODE_PREMUL   = 2'd2,
        MODE_STRAIGHT = 2'd3
    } cur_mode_e;

    typedef struct packed {
        logic [CHAN_W-1:0] red;
        logic [CHAN_W-1:0] green;
        logic [CHAN_W-1:0] blue;
    } rgb_t;

    typedef struct packed {
        logic      enable;
        cur_mode_e mode;
        logic      magnify;
        logic      clamp;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [POS_W-1:0]  x;
        logic [POS_W-1:0]  y;
        logic [HOT_W-1:0]  hx;
        logic [HOT_W-1:0]  hy;
        rgb_t              col_a;
        rgb_t              col_b;
        logic [SIZE_W-1:0] wm1;
        logic [SIZE_W-1:0] hm1;
    } shape_t;

    typedef struct packed {
        logic [AHI_W-1:0] hi;
        logic [ALO_W-1:0] lo;
    } addr_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.enable  = w[0];
        c.mode    = cur_mode_e'(w[2:1]);
        c.magnify = w[3];
        c.clamp   = w[4];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[0]   = c.enable;
        w[2:1] = c.mode;
        w[3]   = c.magnify;
        w[4]   = c.clamp;
        return w;
    endfunction

    function automatic rgb_t rgb_from_word(input logic [DATA_W-1:0] w);
        rgb_t c;
        c.blue  = w[0 +: CHAN_W];
        c.green = w[CHAN_W +: CHAN_W];
        c.red   = w[2*CHAN_W +: CHAN_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] rgb_to_word(input rgb_t c);
        logic [DATA_W-1:0] w;
        w                     = '0;
        w[0 +: CHAN_W]        = c.blue;
        w[CHAN_W +: CHAN_W]   = c.green;
        w[2*CHAN_W +: CHAN_W] = c.red;
        return w;
    endfunction

    function automatic logic [DIM_W-1:0] dim_decode(input logic [SIZE_W-1:0] m1);
        return {1'b0, m1} + DIM_W'(1);
    endfunction

    function automatic logic [ALO_W-1:0] align_low(input logic [ALO_W-1:0] lo);
        logic [ALO_W-1:0] r;
        r                   = lo;
        r[ALIGN_BITS-1:0]   = '0;
        return r;
    endfunction

endpackage

// File: rtl/cursor_commit_ctrl.sv
module cursor_commit_ctrl
    import cursor_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_lock_bit,
    input  logic              frame_start,
    output logic              lock_o,
    output logic              commit_o
);
    logic lock_q;
    logic lock_wr;
    logic unlock;

    assign lock_wr  = wr_en && (wr_addr == REG_LOCK);
    assign unlock   = lock_wr && !wr_lock_bit && lock_q;
    assign commit_o = unlock || (frame_start && !lock_q);
    assign lock_o   = lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (lock_wr) begin
            lock_q <= wr_lock_bit;
        end
    end

    // R10: a clear-write while already unlocked never commits by itself
    a_r10_no_spurious_unlock: assert property (@(posedge clk) disable iff (rst)
        (lock_wr && !wr_lock_bit && !lock_q && !frame_start) |-> !commit_o);

endmodule

// File: rtl/cursor_pending_bank.sv
module cursor_pending_bank
    import cursor_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_i,
    output shape_t            shape_o,
    output addr_t             addr_o,
    output logic              armed_o
);
    shape_t shape_q;
    addr_t  addr_q;
    logic   armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shape_q <= '0;
            addr_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CTRL: shape_q.ctrl  <= ctrl_from_word(wr_data);
                REG_POS: begin
                    shape_q.x <= wr_data[0 +: POS_W];
                    shape_q.y <= wr_data[POS_Y_LSB +: POS_W];
                end
                REG_HOT: begin
                    shape_q.hx <= wr_data[0 +: HOT_W];
                    shape_q.hy <= wr_data[HOT_Y_LSB +: HOT_W];
                end
                REG_COLA: shape_q.col_a <= rgb_from_word(wr_data);
                REG_COLB: shape_q.col_b <= rgb_from_word(wr_data);
                REG_SIZE: begin
                    shape_q.wm1 <= wr_data[0 +: SIZE_W];
                    shape_q.hm1 <= wr_data[SIZE_H_LSB +: SIZE_W];
                end
                REG_AHI: addr_q.hi <= wr_data[0 +: AHI_W];
                REG_ALO: addr_q.lo <= wr_data[0 +: ALO_W];
                default: ;
            endcase
        end
    end

    // Arm flag: low write arms, high write disarms, a commit consumes it.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (wr_en && (wr_addr == REG_ALO)) begin
            armed_q <= 1'b1;
        end else if (wr_en && (wr_addr == REG_AHI)) begin
            armed_q <= 1'b0;
        end else if (commit_i) begin
            armed_q <= 1'b0;
        end
    end

    assign shape_o = shape_q;
    assign addr_o  = addr_q;
    assign armed_o = armed_q;

    // R11: writes outside the map leave all pending state alone
    a_r11_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr > REG_ALO)) |=> ($stable(shape_q) && $stable(addr_q)));

endmodule

// File: rtl/cursor_active_bank.sv
module cursor_active_bank
    import cursor_regs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   commit_i,
    input  logic   armed_i,
    input  shape_t pend_shape_i,
    input  addr_t  pend_addr_i,
    output shape_t shape_o,
    output addr_t  addr_o
);
    shape_t shape_q;
    addr_t  addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shape_q <= '0;
        end else if (commit_i) begin
            shape_q <= pend_shape_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (commit_i && armed_i) begin
            addr_q.hi <= pend_addr_i.hi;
            addr_q.lo <= align_low(pend_addr_i.lo);
        end
    end

    assign shape_o = shape_q;
    assign addr_o  = addr_q;

    // R4: a commit transfers the whole pending shape in one edge
    a_r4_commit_all: assert property (@(posedge clk) disable iff (rst)
        commit_i |=> (shape_q == $past(pend_shape_i)));

    // R7: the address only moves on an armed commit
    a_r7_addr_needs_arm: assert property (@(posedge clk) disable iff (rst)
        !(commit_i && armed_i) |=> $stable(addr_q));

endmodule

// File: rtl/cursor_readback.sv
module cursor_readback
    import cursor_regs_pkg::*;
(
    input  logic              rd_view,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              lock_i,
    input  shape_t            pend_shape_i,
    input  addr_t             pend_addr_i,
    input  shape_t            act_shape_i,
    input  addr_t             act_addr_i,
    output logic [DATA_W-1:0] rd_data
);
    shape_t s;
    addr_t  a;

    always_comb begin
        s       = rd_view ? act_shape_i : pend_shape_i;
        a       = rd_view ? act_addr_i  : pend_addr_i;
        rd_data = '0;
        case (rd_addr)
            REG_LOCK: rd_data[0] = lock_i;
            REG_CTRL: rd_data = ctrl_to_word(s.ctrl);
            REG_POS: begin
                rd_data[0 +: POS_W]         = s.x;
                rd_data[POS_Y_LSB +: POS_W] = s.y;
            end
            REG_HOT: begin
                rd_data[0 +: HOT_W]         = s.hx;
                rd_data[HOT_Y_LSB +: HOT_W] = s.hy;
            end
            REG_COLA: rd_data = rgb_to_word(s.col_a);
            REG_COLB: rd_data = rgb_to_word(s.col_b);
            REG_SIZE: begin
                rd_data[0 +: SIZE_W]          = s.wm1;
                rd_data[SIZE_H_LSB +: SIZE_W] = s.hm1;
            end
            REG_AHI: rd_data[0 +: AHI_W] = a.hi;
            REG_ALO: rd_data[0 +: ALO_W] = a.lo;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cursor_regbank.sv
module cursor_regbank
    import cursor_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_view,
    output logic [DATA_W-1:0] rd_data,
    output logic              cur_enable,
    output logic [1:0]        cur_mode,
    output logic              cur_magnify,
    output logic              cur_clamp,
    output logic [POS_W-1:0]  cur_x,
    output logic [POS_W-1:0]  cur_y,
    output logic [HOT_W-1:0]  cur_hot_x,
    output logic [HOT_W-1:0]  cur_hot_y,
    output logic [RGB_W-1:0]  cur_color0,
    output logic [RGB_W-1:0]  cur_color1,
    output logic [DIM_W-1:0]  cur_width,
    output logic [DIM_W-1:0]  cur_height,
    output logic [BASE_W-1:0] cur_base_addr
);
    logic   lock;
    logic   commit;
    logic   armed;
    shape_t pend_shape;
    addr_t  pend_addr;
    shape_t act_shape;
    addr_t  act_addr;

    cursor_commit_ctrl u_commit (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_lock_bit (wr_data[0]),
        .frame_start (frame_start),
        .lock_o      (lock),
        .commit_o    (commit)
    );

    cursor_pending_bank u_pending (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .commit_i (commit),
        .shape_o  (pend_shape),
        .addr_o   (pend_addr),
        .armed_o  (armed)
    );

    cursor_active_bank u_active (
        .clk          (clk),
        .rst          (rst),
        .commit_i     (commit),
        .armed_i      (armed),
        .pend_shape_i (pend_shape),
        .pend_addr_i  (pend_addr),
        .shape_o      (act_shape),
        .addr_o       (act_addr)
    );

    cursor_readback u_readback (
        .rd_view      (rd_view),
        .rd_addr      (rd_addr),
        .lock_i       (lock),
        .pend_shape_i (pend_shape),
        .pend_addr_i  (pend_addr),
        .act_shape_i  (act_shape),
        .act_addr_i   (act_addr),
        .rd_data      (rd_data)
    );

    assign cur_enable    = act_shape.ctrl.enable;
    assign cur_mode      = act_shape.ctrl.mode;
    assign cur_magnify   = act_shape.ctrl.magnify;
    assign cur_clamp     = act_shape.ctrl.clamp;
    assign cur_x         = act_shape.x;
    assign cur_y         = act_shape.y;
    assign cur_hot_x     = act_shape.hx;
    assign cur_hot_y     = act_shape.hy;
    assign cur_color0    = act_shape.col_a;
    assign cur_color1    = act_shape.col_b;
    assign cur_width     = dim_decode(act_shape.wm1);
    assign cur_height    = dim_decode(act_shape.hm1);
    assign cur_base_addr = act_addr;

    // R3: while locked and no unlock arrives, the renderer view is frozen
    a_r3_frozen_when_locked: assert property (@(posedge clk) disable iff (rst)
        (lock && !(wr_en && (wr_addr == REG_LOCK) && !wr_data[0]))
        |=> ($stable(act_shape) && $stable(act_addr)));

    // R6: decoded dimensions are never zero
    always_comb begin
        if (!rst) begin
            a_r6_dims_nonzero: assert ((cur_width != '0) && (cur_height != '0));
        end
    end

endmodule

// File: tb/cursor_regbank_bench.sv
module cursor_regbank_bench;
    import cursor_regs_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              frame_start = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_view = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              cur_enable, cur_magnify, cur_clamp;
    logic [1:0]        cur_mode;
    logic [POS_W-1:0]  cur_x, cur_y;
    logic [HOT_W-1:0]  cur_hot_x, cur_hot_y;
    logic [RGB_W-1:0]  cur_color0, cur_color1;
    logic [DIM_W-1:0]  cur_width, cur_height;
    logic [BASE_W-1:0] cur_base_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cursor_regbank u_cursor_regbank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_start(frame_start), .rd_addr(rd_addr), .rd_view(rd_view), .rd_data(rd_data),
        .cur_enable(cur_enable), .cur_mode(cur_mode), .cur_magnify(cur_magnify),
        .cur_clamp(cur_clamp), .cur_x(cur_x), .cur_y(cur_y), .cur_hot_x(cur_hot_x),
        .cur_hot_y(cur_hot_y), .cur_color0(cur_color0), .cur_color1(cur_color1),
        .cur_width(cur_width), .cur_height(cur_height), .cur_base_addr(cur_base_addr)
    );

    typedef struct packed {
        logic [3:0]  a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{4'd1, 32'h0000_001D, 32'h0000_001D},
        '{4'd2, 32'hFFFF_FFFF, 32'h1FFF_1FFF},
        '{4'd3, 32'h1234_5678, 32'h0000_5678},
        '{4'd4, 32'hAB11_2233, 32'h0011_2233},
        '{4'd5, 32'h00FF_EE01, 32'h00FF_EE01},
        '{4'd6, 32'h0000_3F1F, 32'h0000_3F1F},
        '{4'd7, 32'h0000_01A5, 32'h0000_00A5},
        '{4'd8, 32'h8765_4FFF, 32'h8765_4FFF},
        '{4'd15, 32'hDEAD_BEEF, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic v, output logic [31:0] d);
        rd_addr = a; rd_view = v;
        #0.5;
        d = rd_data;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 enable", cur_enable, 0);
        check("R1 width", cur_width, 1);
        check("R1 height", cur_height, 1);
        check("R1 addr", cur_base_addr, 0);
        rd(4'd0, 1'b0, d); check("R1 lock", d, 0);
        rd(4'd6, 1'b1, d); check("R1 size act", d, 0);

        wr(4'd0, 32'h1);
        rd(4'd0, 1'b0, d); check("R3 lock set", d, 1);
        // R2 R9 R11 R8: table walk into pending copy while locked
        foreach (VECS[i]) begin
            wr(VECS[i].a, VECS[i].d);
            rd(VECS[i].a, 1'b0, d);
            check("R2 R9 R11 R8 pending readback", d, VECS[i].e);
        end
        rd(4'd2, 1'b1, d); check("R2 active untouched", d, 0);
        pulse_frame();
        // R3
        check("R3 x frozen", cur_x, 0);
        check("R3 enable frozen", cur_enable, 0);
        check("R3 addr frozen", cur_base_addr, 0);

        wr(4'd0, 32'h0);
        // R4 everything at once
        check("R4 enable", cur_enable, 1);
        check("R9 mode", cur_mode, 2);
        check("R9 magnify", cur_magnify, 1);
        check("R9 clamp", cur_clamp, 1);
        check("R4 x", cur_x, 13'h1FFF);
        check("R4 y", cur_y, 13'h1FFF);
        check("R11 hot x", cur_hot_x, 8'h78);
        check("R11 hot y", cur_hot_y, 8'h56);
        check("R11 color0", cur_color0, 24'h112233);
        check("R11 color1", cur_color1, 24'hFFEE01);
        check("R6 width", cur_width, 9'd32);
        check("R6 height", cur_height, 9'd64);
        check("R8 base addr", cur_base_addr, 40'hA5_8765_4000);
        rd(4'd8, 1'b1, d); check("R8 active lo", d, 32'h8765_4000);
        rd(4'd8, 1'b0, d); check("R8 pending lo", d, 32'h8765_4FFF);

        // R10 clear while clear
        wr(4'd2, 32'h0005_0003);
        wr(4'd0, 32'h0);
        check("R10 x held", cur_x, 13'h1FFF);
        pulse_frame();
        check("R5 x", cur_x, 13'd3);
        check("R5 y", cur_y, 13'd5);

        // R7 arm ordering
        wr(4'd7, 32'h11);
        pulse_frame();
        check("R7 high only", cur_base_addr, 40'hA5_8765_4000);
        wr(4'd8, 32'h0000_1000);
        pulse_frame();
        check("R7 high then low", cur_base_addr, 40'h11_0000_1000);
        wr(4'd8, 32'h0000_2000);
        wr(4'd7, 32'h22);
        pulse_frame();
        check("R7 low then high", cur_base_addr, 40'h11_0000_1000);

        // R6 size extremes, R9 mode encodings
        wr(4'd6, 32'h0);
        wr(4'd1, 32'h2);
        pulse_frame();
        check("R6 width min", cur_width, 9'd1);
        check("R6 height min", cur_height, 9'd1);
        check("R9 mode and-mask", cur_mode, 1);
        wr(4'd6, 32'hFFFF);
        wr(4'd1, 32'h6);
        pulse_frame();
        check("R6 width max", cur_width, 9'd256);
        check("R6 height max", cur_height, 9'd256);
        check("R9 mode straight", cur_mode, 3);
        check("R9 enable off", cur_enable, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule